// File: doc/BRIEF.md
# ATA Multiword DMA Strobe Sequencer

This block drives the host side of an ATA/ATAPI multiword DMA transfer. Once a transfer has been armed with a word count and a direction, it waits for the device to request service. It then raises the acknowledge and chip-select lines and produces a train of read or write strobes. Each phase of the handshake lasts a programmed number of system clock cycles.

Five 8-bit timing fields set the phases:

- the acknowledge lead before the first strobe;
- the strobe active width;
- the strobe negated width, held separately for reads and for writes;
- an end-of-cycle extension that keeps the acknowledge up after the final recovery period.

The block also produces two signals for the data path. One enables the write-data drivers. The other is a capture pulse that marks the cycle in which read data is to be latched.

The device may drop its request at the end of any recovery period. When that happens the sequencer releases the bus through the end-of-cycle phase and keeps the remaining word count. It starts again with a fresh lead phase when the request returns. When the last word has been moved and the bus has been released, a one-cycle completion pulse is issued.

Top module: `mdma_strobe_seq`

## Requirements
- R1: After reset every output is low, and a high `dmarq` has no effect while no transfer is armed.
- R2: When a transfer is armed and `dmarq` is sampled high in idle, `dmack_o` and `cs_valid_o` rise in the next cycle and stay high for max(`t_setup`,1) cycles before the first strobe rises.
- R3: Each strobe stays high for max(`t_active`,1) cycles. The strobe is `dior_o` when the latched direction is read (`xfer_write`=0) and `diow_o` when it is write (`xfer_write`=1). The two strobes are never high together.
- R4: After each strobe the strobe stays low with the acknowledge held. This recovery period lasts max(`t_neg_rd`,1) cycles for reads and max(`t_neg_wr`,1) cycles for writes.
- R5: After the recovery that follows the final strobe of a burst, `dmack_o` and `cs_valid_o` stay high for a further max(`t_eoc`,1) cycles and then fall.
- R6: A timing field of zero gives a phase of exactly one cycle.
- R7: In write mode `dout_en_o` is high from the lead phase through the recovery after the last strobe, and low during the end-of-cycle phase. It is never high in read mode.
- R8: `rd_capture_o` pulses high only in the final cycle of each read strobe, so `dior_o` falls in the cycle after it.
- R9: If `dmarq` is low at the end of a recovery period while words remain, the burst releases through the end-of-cycle phase without a completion pulse. It resumes with a new lead phase when `dmarq` is high in idle. The total number of strobes equals the armed word count.
- R10: `done_o` is high for exactly one cycle, in the first idle cycle after the end-of-cycle phase that follows the last word.
- R11: A pulse on `xfer_start` in idle latches `xfer_words` and `xfer_write`. A word count of zero arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | Arms a transfer (honoured only in idle) |
| xfer_write | input | 1 | Direction latched at arm time: 1 write, 0 read |
| xfer_words | input | WCW | Number of words in the transfer |
| dmarq | input | 1 | Device DMA request |
| t_setup | input | TW | Acknowledge lead before the first strobe, in cycles |
| t_active | input | TW | Strobe active width, in cycles |
| t_neg_rd | input | TW | Read strobe negated width, in cycles |
| t_neg_wr | input | TW | Write strobe negated width, in cycles |
| t_eoc | input | TW | End-of-cycle extension, in cycles |
| dmack_o | output | 1 | DMA acknowledge to the device |
| cs_valid_o | output | 1 | Chip-select valid window |
| dior_o | output | 1 | Read strobe |
| diow_o | output | 1 | Write strobe |
| dout_en_o | output | 1 | Write data driver enable |
| rd_capture_o | output | 1 | Read data capture pulse |
| done_o | output | 1 | Transfer completion pulse |

## Verification
The bench compares the outputs cycle by cycle against an expected trace for each burst, so every phase length counts.

- **Zero-valued fields.** A design that let a zero field wrap would hold a phase for 256 cycles instead of one.
- **Separate negated widths.** Reads and writes are run with different negated widths; a design that used the wrong one for a direction would mis-time recovery.
- **Pause on a dropped request.** `dmarq` falls after the first strobe of a burst. A design that ignored the request would run on without releasing the bus, and one that lost the word count would issue too few or too many strobes on resume, or signal completion early.
- **Edges of the handshake.** The bench looks for an unarmed request that starts a burst, a zero-word arm that starts a burst, a capture pulse in the wrong cycle, and write data dropped during the final recovery.

// File: rtl/mdma_pkg.sv
// Package: shared types and helpers for the multiword DMA strobe sequencer.
// Assumes: timing fields are unsigned cycle counts; a zero field means one cycle.
package mdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_ACTIVE  = 3'd2,
        ST_RECOVER = 3'd3,
        ST_EOC     = 3'd4
    } seq_state_t;

endpackage

// File: rtl/mdma_phase_timer.sv
// Module: shared down-counter that times every sequencer phase.
// A load sets the count so that the phase lasts max(value,1) cycles.
// The expired flag is high in the final cycle of the phase.
// Assumes: load is asserted in the cycle before the first cycle of the phase.
module mdma_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt_q;

    // Reload on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - ONE;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/mdma_word_tracker.sv
// Module: keeps the remaining word count and the latched direction.
// Assumes: arm is only honoured in idle, and one decrement happens per completed strobe.
module mdma_word_tracker #(
    parameter int WCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm,
    input  logic           arm_write,
    input  logic [WCW-1:0] arm_words,
    input  logic           dec,
    output logic           words_left,
    output logic           is_write
);
    localparam logic [WCW-1:0] ONE = WCW'(1);

    logic [WCW-1:0] remain_q;
    logic           write_q;

    // Load the word count and direction on arm; count words down as strobes finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            write_q  <= 1'b0;
        end else if (arm) begin
            remain_q <= arm_words;
            write_q  <= arm_write;
        end else if (dec && remain_q != '0) begin
            remain_q <= remain_q - ONE;
        end
    end

    assign words_left = (remain_q != '0);
    assign is_write   = write_q;
endmodule

// File: rtl/mdma_seq_fsm.sv
// Module: phase state machine (idle, lead, active, recovery, end-of-cycle).
// Chooses the timer reload value for the state being entered.
// Assumes: the timer is reloaded on every state change, and the device request
// is sampled only in idle and at the end of a recovery period.
module mdma_seq_fsm
    import mdma_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dmarq,
    input  logic          words_left,
    input  logic          is_write,
    input  logic          expired,
    input  logic [TW-1:0] t_setup,
    input  logic [TW-1:0] t_active,
    input  logic [TW-1:0] t_neg_rd,
    input  logic [TW-1:0] t_neg_wr,
    input  logic [TW-1:0] t_eoc,
    output seq_state_t    state,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          word_done,
    output logic          burst_end
);
    seq_state_t state_q, state_d;

    // Next-state selection for each phase.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (words_left && dmarq) state_d = ST_SETUP;
            ST_SETUP:   if (expired) state_d = ST_ACTIVE;
            ST_ACTIVE:  if (expired) state_d = ST_RECOVER;
            ST_RECOVER: if (expired) state_d = (words_left && dmarq) ? ST_ACTIVE : ST_EOC;
            ST_EOC:     if (expired) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Timer reload value chosen by the state about to be entered.
    always_comb begin
        unique case (state_d)
            ST_SETUP:   tmr_val = t_setup;
            ST_ACTIVE:  tmr_val = t_active;
            ST_RECOVER: tmr_val = is_write ? t_neg_wr : t_neg_rd;
            ST_EOC:     tmr_val = t_eoc;
            default:    tmr_val = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign tmr_load  = (state_d != state_q);
    assign word_done = (state_q == ST_ACTIVE) && expired;
    assign burst_end = (state_q == ST_EOC) && expired;
    assign state     = state_q;
endmodule

// File: rtl/mdma_strobe_seq.sv
// Module: top of the multiword DMA strobe sequencer.
// Joins the word tracker, the phase FSM and the phase timer, and decodes the bus strobes.
// Assumes: timing fields stay stable during a burst. Pad skew and cable delay are
// handled outside this block.
module mdma_strobe_seq
    import mdma_pkg::*;
#(
    parameter int TW  = 8,
    parameter int WCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           xfer_start,
    input  logic           xfer_write,
    input  logic [WCW-1:0] xfer_words,
    input  logic           dmarq,
    input  logic [TW-1:0]  t_setup,
    input  logic [TW-1:0]  t_active,
    input  logic [TW-1:0]  t_neg_rd,
    input  logic [TW-1:0]  t_neg_wr,
    input  logic [TW-1:0]  t_eoc,
    output logic           dmack_o,
    output logic           cs_valid_o,
    output logic           dior_o,
    output logic           diow_o,
    output logic           dout_en_o,
    output logic           rd_capture_o,
    output logic           done_o
);
    seq_state_t    state;
    logic          words_left, is_write, expired;
    logic          tmr_load, word_done, burst_end;
    logic [TW-1:0] tmr_val;
    logic          done_q;
    logic          arm;

    assign arm = xfer_start && (state == ST_IDLE);

    mdma_word_tracker #(.WCW(WCW)) u_words (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .arm_write  (xfer_write),
        .arm_words  (xfer_words),
        .dec        (word_done),
        .words_left (words_left),
        .is_write   (is_write)
    );

    mdma_seq_fsm #(.TW(TW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dmarq      (dmarq),
        .words_left (words_left),
        .is_write   (is_write),
        .expired    (expired),
        .t_setup    (t_setup),
        .t_active   (t_active),
        .t_neg_rd   (t_neg_rd),
        .t_neg_wr   (t_neg_wr),
        .t_eoc      (t_eoc),
        .state      (state),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .word_done  (word_done),
        .burst_end  (burst_end)
    );

    mdma_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    // Completion pulse: end of the end-of-cycle phase with no words left.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= burst_end && !words_left;
    end

    // Bus-side decode from the registered phase state.
    always_comb begin
        dmack_o      = (state != ST_IDLE);
        cs_valid_o   = (state != ST_IDLE);
        dior_o       = (state == ST_ACTIVE) && !is_write;
        diow_o       = (state == ST_ACTIVE) && is_write;
        dout_en_o    = is_write && (state == ST_SETUP || state == ST_ACTIVE ||
                                    state == ST_RECOVER);
        rd_capture_o = (state == ST_ACTIVE) && !is_write && expired;
        done_o       = done_q;
    end
endmodule

// File: rtl/mdma_strobe_seq_checker.sv
// Module: protocol checker for the strobe sequencer. It observes ports only and
// is attached to every instance of the top module.
module mdma_strobe_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic dmack_o,
    input logic cs_valid_o,
    input logic dior_o,
    input logic diow_o,
    input logic dout_en_o,
    input logic rd_capture_o,
    input logic done_o
);
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dior_o && diow_o));

    assert_strobe_under_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dior_o || diow_o) |-> (dmack_o && cs_valid_o));

    assert_ack_leads_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmack_o) |-> (!dior_o && !diow_o));

    assert_capture_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_capture_o |-> dior_o);

    assert_capture_then_negate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_capture_o |=> !dior_o);

    assert_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(diow_o) |-> dout_en_o);

    assert_done_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!dmack_o && !dior_o && !diow_o));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_release_after_negate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dmack_o) |-> $past(!dior_o && !diow_o));
endmodule

bind mdma_strobe_seq mdma_strobe_seq_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .dmack_o      (dmack_o),
    .cs_valid_o   (cs_valid_o),
    .dior_o       (dior_o),
    .diow_o       (diow_o),
    .dout_en_o    (dout_en_o),
    .rd_capture_o (rd_capture_o),
    .done_o       (done_o)
);

// File: tb/test_mdma_strobe_seq.sv
// Scoreboard bench: driver tasks queue the expected per-cycle output vectors,
// and a monitor compares them one cycle at a time after each rising edge.
module test_mdma_strobe_seq;
    localparam int TW  = 8;
    localparam int WCW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           xfer_start = 1'b0;
    logic           xfer_write = 1'b0;
    logic [WCW-1:0] xfer_words = '0;
    logic           dmarq = 1'b0;
    logic [TW-1:0]  t_setup = '0, t_active = '0, t_neg_rd = '0, t_neg_wr = '0, t_eoc = '0;
    logic dmack_o, cs_valid_o, dior_o, diow_o, dout_en_o, rd_capture_o, done_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Vector layout: {done, capture, dout_en, diow, dior, cs_valid, dmack}
    logic [6:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    mdma_strobe_seq #(.TW(TW), .WCW(WCW)) i_mdma_strobe_seq (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_write(xfer_write),
        .xfer_words(xfer_words), .dmarq(dmarq), .t_setup(t_setup), .t_active(t_active),
        .t_neg_rd(t_neg_rd), .t_neg_wr(t_neg_wr), .t_eoc(t_eoc), .dmack_o(dmack_o),
        .cs_valid_o(cs_valid_o), .dior_o(dior_o), .diow_o(diow_o), .dout_en_o(dout_en_o),
        .rd_capture_o(rd_capture_o), .done_o(done_o)
    );

    function automatic logic [6:0] outs();
        return {done_o, rd_capture_o, dout_en_o, diow_o, dior_o, cs_valid_o, dmack_o};
    endfunction

    function automatic int eff(logic [TW-1:0] v);
        return (v == '0) ? 1 : int'(v);
    endfunction

    task automatic check(string tag, logic [6:0] got, logic [6:0] want);
        tests++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, want);
        end
    endtask

    task automatic push(logic [6:0] v, string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Monitor: pop one expectation per cycle, sampled after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), outs(), exp_q.pop_front());
            end
        end
    end

    // Expected trace of one burst segment (lead, strobes, recoveries, release).
    task automatic gen_segment(bit w, int nwords, bit last_seg);
        int tm = eff(t_setup);
        int td = eff(t_active);
        int tk = w ? eff(t_neg_wr) : eff(t_neg_rd);
        int te = eff(t_eoc);
        for (int c = 0; c < tm; c++) push({2'b00, w, 2'b00, 2'b11}, "R2");
        for (int i = 0; i < nwords; i++) begin
            for (int c = 0; c < td; c++)
                push({1'b0, (!w && c == td - 1), w, w, !w, 2'b11}, w ? "R3" : "R8");
            for (int c = 0; c < tk; c++) push({2'b00, w, 2'b00, 2'b11}, w ? "R7" : "R4");
        end
        for (int c = 0; c < te; c++) push({7'b0000011}, "R5");
        push({last_seg, 6'b0}, last_seg ? "R10" : "R9");
        push(7'b0, "R10");
    endtask

    task automatic arm(bit w, int words);
        @(negedge clk);
        xfer_start = 1'b1;
        xfer_write = w;
        xfer_words = WCW'(words);
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic set_timing(int tm, int td, int tkr, int tkw, int te);
        t_setup = TW'(tm); t_active = TW'(td); t_neg_rd = TW'(tkr);
        t_neg_wr = TW'(tkw); t_eoc = TW'(te);
    endtask

    task automatic wait_drain();
        int n = 0;
        while (exp_q.size() > 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (exp_q.size() > 0) begin
            fails++;
            tests++;
            $display("FAIL drain: got %0d pending expected 0", exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic full_burst(bit w, int words);
        arm(w, words);
        gen_segment(w, words, 1'b1);
        dmarq = 1'b1;
        wait_drain();
        dmarq = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", outs(), 7'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", outs(), 7'b0);

        // R1: request with nothing armed is ignored.
        dmarq = 1'b1;
        repeat (4) @(negedge clk) check("R1", outs(), 7'b0);
        dmarq = 1'b0;

        // R11: a zero-word arm starts nothing.
        arm(1'b1, 0);
        dmarq = 1'b1;
        repeat (4) @(negedge clk) check("R11", outs(), 7'b0);
        dmarq = 1'b0;

        // Read burst: R2, R3, R4, R5, R8, R10, R11.
        set_timing(2, 3, 2, 5, 1);
        full_burst(1'b0, 3);

        // Write burst with its own negated width: R4, R7.
        set_timing(1, 2, 6, 3, 2);
        full_burst(1'b1, 2);

        // All fields zero: R6.
        set_timing(0, 0, 0, 0, 0);
        full_burst(1'b1, 2);
        full_burst(1'b0, 2);

        // Single-word read with a long end-of-cycle extension: R5.
        set_timing(3, 1, 1, 1, 4);
        full_burst(1'b0, 1);

        // Pause and resume: R9.
        set_timing(1, 2, 1, 2, 2);
        arm(1'b0, 4);
        gen_segment(1'b0, 1, 1'b0);
        dmarq = 1'b1;
        @(negedge clk);
        dmarq = 1'b0;
        wait_drain();
        repeat (3) @(negedge clk) check("R9", outs(), 7'b0);
        gen_segment(1'b0, 3, 1'b1);
        dmarq = 1'b1;
        wait_drain();
        dmarq = 1'b0;

        // R10: after completion, a held request does not restart.
        dmarq = 1'b1;
        repeat (3) @(negedge clk) check("R10", outs(), 7'b0);
        dmarq = 1'b0;

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule